// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This block collects up to four banks of 32 level-sensitive interrupt lines and steers each line to one of two processor request outputs: a normal request and a fast request. Software configures it through a 32-bit register port that decodes a 4 KB window. Each line has its own 6-bit priority and a select bit that places it on the fast path. Each bank has a mask, a software-interrupt vector, a raw-input view and two pending views, one per path. The mask and the software bits are changed through separate set and clear addresses, so a single write changes only the bits it names.

Each path works as a latch that software re-arms. While a path is armed and some unmasked line is active on it, the controller records the winning line number as that path's source code and raises the path's output. The output stays high, and the code stays fixed, until software writes the re-arm bit for that path. A global mask bit stops any new request from being raised.

A soft-reset bit in the configuration register returns all software state to its reset values. A status register always reads 1 to show that reset has completed. A protection bit, two idle bits and an auto-idle bit are only stored and read back. They have no other effect.

Top module: `lvl_intc`

## Requirements
- R1: After reset every mask bit reads 1. Software bits, select bits and priorities read 0. Both outputs are low, both source codes read 0 and the control register reads 0.
- R2: Bank b's registers start at 0x080 + 0x20·b, with these word offsets: 0x00 raw input (read only), 0x04 mask, 0x08 mask-clear, 0x0C mask-set, 0x10 software-set (reads the software bits), 0x14 software-clear, 0x18 normal pending view, 0x1C fast pending view. Pending is raw OR software. The normal view reads pending AND NOT mask AND NOT select. The fast view reads pending AND NOT mask AND select.
- R3: A write to the mask word replaces the bank mask. A mask-clear write clears the bits set in the data. A mask-set write sets the bits set in the data.
- R4: Software-set ORs the data into the software bits and software-clear clears the named bits. Inputs are level only, so pending always equals the active inputs OR the remaining software bits, whether a software bit is cleared or an input drops.
- R5: The line register for line l of bank b sits at 0x100 + 0x80·b + 4·l. Bits 7:2 hold the priority and bit 0 the fast-path select. A read returns the same fields with every other bit 0.
- R6: Among the unmasked pending lines on a path, the lowest priority value wins. On a tie the higher line number wins. Its line number (bank·32 + line) is captured as the source code, readable at 0x040 (normal) and 0x044 (fast), and it stays unchanged while that output is high.
- R7: A line sampled as active raises an armed, enabled path's output two clock edges after it reaches the input, or one edge after a software-set or re-arm write. The output then stays high until control (0x048) is written with bit 0 (normal) or bit 1 (fast), which drops that output at the next edge and re-arms the path.
- R8: Control bit 2 is the global mask. While it is 1 no output rises, and it reads back in bit 2. Clearing it lets an armed path fire.
- R9: Writing bit 1 of the configuration register (0x010) performs a soft reset to the R1 state. Bit 0 is a stored auto-idle bit. The status register at 0x014 always reads 1.
- R10: Writes to the revision (0x000), status, source-code, raw-input and pending-view addresses change nothing. The protection bit (0x04C bit 0) and the idle bits (0x050 bits 1:0) read back as written and have no effect on the outputs. The revision reads the REVISION parameter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Byte address within the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| line_in | input | 32·NBANKS | Level-sensitive interrupt lines |
| nrm_irq_o | output | 1 | Normal-path request |
| fast_irq_o | output | 1 | Fast-path request |

## Verification
The bench drives each of the 64 lines of a two-bank build in turn and checks the source code, the raw view and the pending view. A wrong bank offset or a wrong line index would report the wrong code or set the wrong bit. It runs priority ties across banks, where an arbiter that favoured low indices would name line 7 instead of 40. It also checks that a software clear does not drop a pending bit that a held input still drives. It confirms that the outputs stay latched after their source goes away, and that writes to read-only addresses leave the views unchanged. A design without the hold would drop the request early. A design that let the global mask or a read-only write alter state would show a wrong readback.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int LINES_PER_BANK = 32;

    localparam logic [11:0] A_REV    = 12'h000;
    localparam logic [11:0] A_SYSCFG = 12'h010;
    localparam logic [11:0] A_STATUS = 12'h014;
    localparam logic [11:0] A_CODE_N = 12'h040;
    localparam logic [11:0] A_CODE_F = 12'h044;
    localparam logic [11:0] A_CTRL   = 12'h048;
    localparam logic [11:0] A_PROT   = 12'h04C;
    localparam logic [11:0] A_IDLE   = 12'h050;
    localparam logic [11:0] A_LINE0  = 12'h100;

    // control word bits
    localparam int CB_REARM_N = 0;
    localparam int CB_REARM_F = 1;
    localparam int CB_GMASK   = 2;

    // word index within a bank block
    typedef enum logic [2:0] {
        BR_RAW  = 3'd0,
        BR_MASK = 3'd1,
        BR_MCLR = 3'd2,
        BR_MSET = 3'd3,
        BR_SSET = 3'd4,
        BR_SCLR = 3'd5,
        BR_PNRM = 3'd6,
        BR_PFST = 3'd7
    } bank_reg_e;
endpackage

// File: rtl/intc_prio_arb.sv
module intc_prio_arb #(
    parameter int N  = 96,
    parameter int PW = 6,
    localparam int CW = $clog2(N)
) (
    input  logic [N-1:0]         active,
    input  logic [N-1:0][PW-1:0] pri,
    output logic                 any,
    output logic [CW-1:0]        win
);
    logic [PW-1:0] best_pri;

    // ascending scan with <= : lowest value wins, ties go to the higher index
    always_comb begin
        any      = 1'b0;
        win      = '0;
        best_pri = '0;
        for (int i = 0; i < N; i++) begin
            if (active[i] && (!any || pri[i] <= best_pri)) begin
                any      = 1'b1;
                best_pri = pri[i];
                win      = CW'(i);
            end
        end
    end
endmodule

// File: rtl/intc_path_ctl.sv
module intc_path_ctl #(
    parameter int CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          soft_rst,
    input  logic          rearm,
    input  logic          enable,
    input  logic          any,
    input  logic [CW-1:0] win,
    output logic          irq_o,
    output logic [CW-1:0] code_o
);
    typedef struct packed {
        logic          armed;
        logic          req;
        logic [CW-1:0] code;
    } path_t;

    localparam path_t P_RST = '{armed: 1'b1, req: 1'b0, code: '0};

    path_t p_d, p_q;

    always_comb begin
        p_d = p_q;
        if (soft_rst) begin
            p_d = P_RST;
        end else if (rearm) begin
            p_d.req   = 1'b0;
            p_d.armed = 1'b1;
        end else if (p_q.armed && any && enable) begin
            p_d.armed = 1'b0;
            p_d.req   = 1'b1;
            p_d.code  = win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= P_RST;
        else        p_q <= p_d;
    end

    assign irq_o  = p_q.req;
    assign code_o = p_q.code;
endmodule

// File: rtl/lvl_intc.sv
module lvl_intc
    import intc_pkg::*;
#(
    parameter int           NBANKS   = 3,
    parameter int           PRI_W    = 6,
    parameter logic [7:0]   REVISION = 8'h21
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [11:0]            reg_addr,
    input  logic [31:0]            reg_wdata,
    output logic [31:0]            reg_rdata,
    input  logic [32*NBANKS-1:0]   line_in,
    output logic                   nrm_irq_o,
    output logic                   fast_irq_o
);
    localparam int NLINES = LINES_PER_BANK * NBANKS;
    localparam int CW     = $clog2(NLINES);
    localparam int NPATH  = 2;

    typedef struct packed {
        logic [NLINES-1:0]            raw;
        logic [NLINES-1:0]            mask;
        logic [NLINES-1:0]            swi;
        logic [NLINES-1:0]            sel;
        logic [NLINES-1:0][PRI_W-1:0] pri;
        logic                         gmask;
        logic                         autoidle;
        logic                         prot;
        logic [1:0]                   idle;
    } st_t;

    localparam st_t ST_RST = '{raw: '0, mask: '1, swi: '0, sel: '0, pri: '0,
                               gmask: 1'b0, autoidle: 1'b0, prot: 1'b0, idle: '0};

    st_t st_d, st_q;

    // address decode
    logic          bank_hit, line_hit, soft_rst;
    bank_reg_e     breg;
    int            bank_no, line_idx;
    logic [11:0]   line_off;

    always_comb begin
        bank_no  = int'(reg_addr[6:5]);
        breg     = bank_reg_e'(reg_addr[4:2]);
        bank_hit = (reg_addr[11:7] == 5'd1) && (bank_no < NBANKS);
        line_off = reg_addr - A_LINE0;
        line_hit = (reg_addr >= A_LINE0) && (int'(line_off[11:7]) < NBANKS);
        line_idx = int'(line_off[11:7]) * LINES_PER_BANK + int'(line_off[6:2]);
    end

    // pending and per-path activity
    logic [NLINES-1:0]            pend;
    logic [NPATH-1:0][NLINES-1:0] act;
    logic [NPATH-1:0]             rearm, path_any, path_irq;
    logic [NPATH-1:0][CW-1:0]     path_win, path_code;

    assign pend   = st_q.raw | st_q.swi;
    assign act[0] = pend & ~st_q.mask & ~st_q.sel;
    assign act[1] = pend & ~st_q.mask &  st_q.sel;

    always_comb begin
        rearm[0] = reg_we && (reg_addr == A_CTRL) && reg_wdata[CB_REARM_N];
        rearm[1] = reg_we && (reg_addr == A_CTRL) && reg_wdata[CB_REARM_F];
    end

    // next-state
    always_comb begin
        st_d     = st_q;
        st_d.raw = line_in;
        soft_rst = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                A_SYSCFG: begin
                    st_d.autoidle = reg_wdata[0];
                    soft_rst      = reg_wdata[1];
                end
                A_CTRL: st_d.gmask = reg_wdata[CB_GMASK];
                A_PROT: st_d.prot  = reg_wdata[0];
                A_IDLE: st_d.idle  = reg_wdata[1:0];
                default: begin
                    if (bank_hit) begin
                        for (int b = 0; b < NBANKS; b++) begin
                            if (b == bank_no) begin
                                case (breg)
                                    BR_MASK: st_d.mask[b*32 +: 32] = reg_wdata;
                                    BR_MCLR: st_d.mask[b*32 +: 32] = st_q.mask[b*32 +: 32] & ~reg_wdata;
                                    BR_MSET: st_d.mask[b*32 +: 32] = st_q.mask[b*32 +: 32] | reg_wdata;
                                    BR_SSET: st_d.swi[b*32 +: 32]  = st_q.swi[b*32 +: 32] | reg_wdata;
                                    BR_SCLR: st_d.swi[b*32 +: 32]  = st_q.swi[b*32 +: 32] & ~reg_wdata;
                                    default: ;
                                endcase
                            end
                        end
                    end
                    if (line_hit) begin
                        for (int i = 0; i < NLINES; i++) begin
                            if (i == line_idx) begin
                                st_d.pri[i] = reg_wdata[PRI_W+1:2];
                                st_d.sel[i] = reg_wdata[0];
                            end
                        end
                    end
                end
            endcase
        end
        if (soft_rst) begin
            st_d     = ST_RST;
            st_d.raw = line_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    // one arbiter and one request latch per path
    for (genvar g = 0; g < NPATH; g++) begin : g_path
        intc_prio_arb #(.N(NLINES), .PW(PRI_W)) u_arb (
            .active (act[g]),
            .pri    (st_q.pri),
            .any    (path_any[g]),
            .win    (path_win[g])
        );
        intc_path_ctl #(.CW(CW)) u_ctl (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .rearm    (rearm[g]),
            .enable   (!st_q.gmask),
            .any      (path_any[g]),
            .win      (path_win[g]),
            .irq_o    (path_irq[g]),
            .code_o   (path_code[g])
        );
    end

    assign nrm_irq_o  = path_irq[0];
    assign fast_irq_o = path_irq[1];

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_REV:    reg_rdata = {24'd0, REVISION};
            A_SYSCFG: reg_rdata = {31'd0, st_q.autoidle};
            A_STATUS: reg_rdata = 32'd1;
            A_CODE_N: reg_rdata = 32'(path_code[0]);
            A_CODE_F: reg_rdata = 32'(path_code[1]);
            A_CTRL:   reg_rdata = {29'd0, st_q.gmask, 2'b00};
            A_PROT:   reg_rdata = {31'd0, st_q.prot};
            A_IDLE:   reg_rdata = {30'd0, st_q.idle};
            default: begin
                if (bank_hit) begin
                    for (int b = 0; b < NBANKS; b++) begin
                        if (b == bank_no) begin
                            case (breg)
                                BR_RAW:  reg_rdata = st_q.raw[b*32 +: 32];
                                BR_MASK: reg_rdata = st_q.mask[b*32 +: 32];
                                BR_SSET: reg_rdata = st_q.swi[b*32 +: 32];
                                BR_PNRM: reg_rdata = act[0][b*32 +: 32];
                                BR_PFST: reg_rdata = act[1][b*32 +: 32];
                                default: reg_rdata = '0;
                            endcase
                        end
                    end
                end
                if (line_hit) begin
                    for (int i = 0; i < NLINES; i++) begin
                        if (i == line_idx)
                            reg_rdata = 32'({st_q.pri[i], 1'b0, st_q.sel[i]});
                    end
                end
            end
        endcase
    end
endmodule

// File: rtl/lvl_intc_chk.sv
module lvl_intc_chk #(
    parameter int CW = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          reg_we,
    input logic [11:0]   reg_addr,
    input logic [31:0]   reg_wdata,
    input logic [31:0]   reg_rdata,
    input logic          nrm_o,
    input logic          fast_o,
    input logic          gmask,
    input logic          nrm_any,
    input logic          fast_any,
    input logic [CW-1:0] nrm_code,
    input logic [CW-1:0] fast_code
);
    assert_status_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 12'h014) |-> (reg_rdata == 32'd1));

    assert_nrm_rise_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nrm_o) |-> ($past(nrm_any) && !$past(gmask)));

    assert_fast_rise_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fast_o) |-> ($past(fast_any) && !$past(gmask)));

    assert_rearm_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == 12'h048 && reg_wdata[0]) |=> !nrm_o);

    assert_nrm_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (nrm_o && $past(nrm_o)) |-> $stable(nrm_code));

    assert_fast_code_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fast_o && $past(fast_o)) |-> $stable(fast_code));
endmodule

bind lvl_intc lvl_intc_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .nrm_o     (nrm_irq_o),
    .fast_o    (fast_irq_o),
    .gmask     (st_q.gmask),
    .nrm_any   (path_any[0]),
    .fast_any  (path_any[1]),
    .nrm_code  (path_code[0]),
    .fast_code (path_code[1])
);

// File: tb/tb_lvl_intc.sv
module tb_lvl_intc;
    localparam int NB = 2;
    localparam int NL = 32 * NB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          reg_we;
    logic [11:0]   reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NL-1:0] line_in;
    logic          nrm_irq_o, fast_irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    lvl_intc #(.NBANKS(NB), .PRI_W(6), .REVISION(8'h21)) dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .line_in(line_in),
        .nrm_irq_o(nrm_irq_o), .fast_irq_o(fast_irq_o)
    );

    function automatic logic [11:0] breg(int b, int r);
        return 12'(12'h080 + b * 32 + r * 4);
    endfunction

    function automatic logic [11:0] lreg(int idx);
        return 12'(12'h100 + (idx / 32) * 128 + (idx % 32) * 4);
    endfunction

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chkrd(string tag, logic [11:0] a, logic [31:0] exp);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog got %h exp %h", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; line_in = '0;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        chkrd("R1 mask b0", breg(0, 1), 32'hFFFF_FFFF);
        chkrd("R1 mask b1", breg(1, 1), 32'hFFFF_FFFF);
        chkrd("R1 swi b0", breg(0, 4), 32'h0);
        chkrd("R1 line reg", lreg(10), 32'h0);
        chkrd("R1 code n", 12'h040, 32'h0);
        chkrd("R1 ctrl", 12'h048, 32'h0);
        chkrd("R9 status", 12'h014, 32'h1);
        chk("R1 nrm out", 32'(nrm_irq_o), 32'h0);
        chk("R1 fast out", 32'(fast_irq_o), 32'h0);
        chkrd("R10 revision", 12'h000, 32'h21);

        // R3 mask set/clear/replace
        wr(breg(0, 2), 32'h0000_00F0);
        chkrd("R3 mask clear", breg(0, 1), 32'hFFFF_FF0F);
        wr(breg(0, 3), 32'h0000_0010);
        chkrd("R3 mask set", breg(0, 1), 32'hFFFF_FF1F);
        wr(breg(1, 1), 32'h1234_5678);
        chkrd("R3 mask write", breg(1, 1), 32'h1234_5678);
        wr(breg(0, 1), 32'h0);
        wr(breg(1, 1), 32'h0);

        // R2 / R4 software bits and views
        wr(breg(1, 4), 32'h5);
        chkrd("R4 swi set", breg(1, 4), 32'h5);
        chkrd("R2 pend nrm", breg(1, 6), 32'h5);
        chkrd("R2 pend fast", breg(1, 7), 32'h0);
        wr(lreg(34), 32'h1);
        chkrd("R2 nrm after sel", breg(1, 6), 32'h1);
        chkrd("R2 fast after sel", breg(1, 7), 32'h4);
        wr(breg(1, 5), 32'h5);
        chkrd("R4 swi clear", breg(1, 4), 32'h0);
        chkrd("R4 pend after clear", breg(1, 6), 32'h0);
        wr(lreg(34), 32'h0);

        // R6 / R7 single-line sweep
        for (int i = 0; i < NL; i++) begin
            line_in = NL'(1) << i;
            wr(12'h048, 32'h1);
            step(1);
            chk($sformatf("R7 out line %0d", i), 32'(nrm_irq_o), 32'h1);
            chkrd($sformatf("R6 code line %0d", i), 12'h040, 32'(i));
            chkrd($sformatf("R2 raw line %0d", i), breg(i / 32, 0), 32'h1 << (i % 32));
            chkrd($sformatf("R2 view line %0d", i), breg(i / 32, 6), 32'h1 << (i % 32));
        end
        line_in = '0;
        step(2);

        // R7 hold and re-arm
        chk("R7 held after drop", 32'(nrm_irq_o), 32'h1);
        chkrd("R6 code held", 12'h040, 32'd63);
        wr(12'h048, 32'h1);
        step(1);
        chk("R7 low after rearm", 32'(nrm_irq_o), 32'h0);
        line_in = NL'(1) << 9;
        step(2);
        chk("R7 fires when armed", 32'(nrm_irq_o), 32'h1);
        chkrd("R6 code 9", 12'h040, 32'd9);

        // R4 level-only pending
        wr(breg(0, 4), 32'h200);
        wr(breg(0, 5), 32'h200);
        chkrd("R4 input keeps pend", breg(0, 6), 32'h200);
        wr(breg(0, 4), 32'h200);
        line_in = '0;
        step(2);
        chkrd("R4 swi keeps pend", breg(0, 6), 32'h200);
        wr(breg(0, 5), 32'h200);
        chkrd("R4 pend cleared", breg(0, 6), 32'h0);

        // R6 priority and ties
        wr(lreg(3), 32'd40);
        wr(lreg(7), 32'd16);
        wr(lreg(40), 32'd16);
        chkrd("R5 line reg read", lreg(7), 32'd16);
        line_in = (NL'(1) << 3) | (NL'(1) << 7) | (NL'(1) << 40);
        step(2);
        wr(12'h048, 32'h1);
        step(1);
        chkrd("R6 tie higher index", 12'h040, 32'd40);
        wr(lreg(40), 32'd80);
        wr(12'h048, 32'h1);
        step(1);
        chkrd("R6 lower value wins", 12'h040, 32'd7);
        wr(lreg(3), 32'd8);
        wr(12'h048, 32'h1);
        step(1);
        chkrd("R6 line 3 wins", 12'h040, 32'd3);

        // R5 fast select
        wr(lreg(7), 32'd17);
        chkrd("R5 sel readback", lreg(7), 32'd17);
        wr(12'h048, 32'h3);
        step(1);
        chk("R5 fast out", 32'(fast_irq_o), 32'h1);
        chkrd("R5 fast code", 12'h044, 32'd7);
        chkrd("R5 nrm code", 12'h040, 32'd3);
        chkrd("R2 fast view", breg(0, 7), 32'h80);
        chkrd("R2 nrm view", breg(0, 6), 32'h8);

        // R8 global mask
        wr(12'h048, 32'h5);
        step(2);
        chk("R8 masked stays low", 32'(nrm_irq_o), 32'h0);
        chk("R8 fast untouched", 32'(fast_irq_o), 32'h1);
        chkrd("R8 ctrl read", 12'h048, 32'h4);
        wr(12'h048, 32'h0);
        step(1);
        chk("R8 unmask fires", 32'(nrm_irq_o), 32'h1);

        // R10 ignored writes and stored bits
        wr(12'h040, 32'h3F);
        chkrd("R10 code ro", 12'h040, 32'd3);
        wr(12'h014, 32'h0);
        chkrd("R10 status ro", 12'h014, 32'h1);
        wr(breg(0, 0), 32'h0);
        chkrd("R10 raw ro", breg(0, 0), 32'h88);
        wr(breg(0, 6), 32'h0);
        chkrd("R10 pend ro", breg(0, 6), 32'h8);
        wr(12'h000, 32'h0);
        chkrd("R10 revision ro", 12'h000, 32'h21);
        wr(12'h04C, 32'h1);
        chkrd("R10 prot", 12'h04C, 32'h1);
        wr(12'h050, 32'h3);
        chkrd("R10 idle", 12'h050, 32'h3);
        wr(12'h010, 32'h1);
        chkrd("R9 autoidle", 12'h010, 32'h1);
        chk("R10 outputs kept", {30'd0, nrm_irq_o, fast_irq_o}, 32'h3);

        // R9 soft reset
        line_in = '0;
        wr(12'h010, 32'h2);
        step(1);
        chkrd("R9 mask", breg(0, 1), 32'hFFFF_FFFF);
        chkrd("R9 line reg", lreg(7), 32'h0);
        chkrd("R9 sysconfig", 12'h010, 32'h0);
        chkrd("R9 idle", 12'h050, 32'h0);
        chkrd("R9 prot", 12'h04C, 32'h0);
        chkrd("R9 code", 12'h040, 32'h0);
        chk("R9 outputs low", {30'd0, nrm_irq_o, fast_irq_o}, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule